// File: doc/BRIEF.md
# Buffered Input Capture Bank

This block timestamps external events against a free-running counter that lives elsewhere. It has four capture channels, numbered 0 to 3. Each channel watches one input pin. On the chosen transition of that pin, the channel stores the counter value in a capture register that software can only read, and it raises the channel's flag. Software lowers a flag with a one-cycle clear strobe.

The channels form pairs. Channel 0 pairs with channel 2, and channel 1 pairs with channel 3. Each pair has a history switch. With the switch on, the second channel of the pair stops sampling its own pin. It becomes a one-deep history of the first channel instead: every capture on the first channel moves the previous timestamp across before storing the new one. Software can then read two consecutive event times, for example to measure a pulse width or a period. In this mode, unequal edge selects for the two channels of the pair make the first channel capture on both transitions.

Pins are asynchronous to the clock. They pass through a two-flop synchronizer before edge detection.

Top module: `input_capture_bank`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every capture register reads 0 and every flag reads 0.
- R2: A channel captures on the rising edge of its pin when its `edge_sel_i` bit is 1 and on the falling edge when that bit is 0. The register is loaded with the value of `count_i`. A transition of the other polarity leaves the register unchanged.
- R3: Every capture sets that channel's flag (bit i of `flag_o`).
- R4: A capture overwrites the register even when the channel's flag is already set.
- R5: A pin transition made between two clock edges is captured on the third rising edge that follows it, using the `count_i` value present at that edge. Until then the flag is unchanged. One transition produces exactly one capture.
- R6: A high `flag_clr_i` bit clears that flag at the next edge. If a capture on the same channel occurs at that edge, the flag stays set.
- R7: With `buf_en_i[p]` set (p = 0 or 1), a capture on channel p copies the old contents of register p into register p+2 at the same edge as register p is loaded. The flag of channel p+2 is not set by this copy.
- R8: With `buf_en_i[p]` set, channel p captures on both edges when `edge_sel_i[p]` and `edge_sel_i[p+2]` differ. When they are equal, it captures only on the edge they select.
- R9: With `buf_en_i[p]` set, transitions on pin p+2 change neither register p+2 nor flag p+2.
- R10: With `buf_en_i[p]` clear, channel p+2 captures from its own pin under R2 to R6, independently of channel p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_i | input | 16 | Free-running counter value to timestamp with |
| cap_pin_i | input | 4 | Asynchronous capture pins, bit i drives channel i |
| edge_sel_i | input | 4 | Edge select per channel: 1 selects rising, 0 selects falling |
| buf_en_i | input | 2 | Bit p turns channel p+2 into the history of channel p |
| flag_clr_i | input | 4 | One-cycle flag clear strobes, bit i for channel i |
| cap_data_o | output | 64 | Capture registers; channel i occupies bits [16*i+15 : 16*i] |
| flag_o | output | 4 | Capture flags, bit i for channel i |

## Verification
The assertions assume that `edge_sel_i` and `buf_en_i` stay constant while a pin transition is still inside the synchronizer. They also assume the pins are low at reset. The stimulus follows both rules. It changes the configuration only after four quiet cycles, and it holds `count_i` steady over each capture window, so the expected timestamp is known without any cycle guessing. A separate directed case advances the counter every cycle to pin down the three-edge latency.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;

  // Pick the pulse that matches a single edge selection.
  function automatic logic edge_match(input logic sel, input logic rise, input logic fall);
    return (edge_kind_e'(sel) == EDGE_RISE) ? rise : fall;
  endfunction

  // Primary channel trigger: in history mode, unequal selects mean both edges.
  function automatic logic prim_trigger(input logic hist, input logic sel_p, input logic sel_s,
                                        input logic rise, input logic fall);
    if (hist && (sel_p != sel_s))
      return rise | fall;
    return edge_match(sel_p, rise, fall);
  endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] last_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~last_q;
  assign fall_o = ~chain[STAGES-1] & last_q;

endmodule

// File: rtl/icap_trigger.sv
module icap_trigger
  import icap_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  localparam int NCH = 2 * NUM_PAIRS
) (
  input  logic [NCH-1:0]       rise_i,
  input  logic [NCH-1:0]       fall_i,
  input  logic [NCH-1:0]       edge_sel_i,
  input  logic [NUM_PAIRS-1:0] buf_en_i,
  output logic [NUM_PAIRS-1:0] cap_prim_o,
  output logic [NUM_PAIRS-1:0] cap_sec_o
);

  genvar p;
  generate
    for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
      localparam int SI = p + NUM_PAIRS;
      always_comb begin
        cap_prim_o[p] = prim_trigger(buf_en_i[p], edge_sel_i[p], edge_sel_i[SI],
                                     rise_i[p], fall_i[p]);
        cap_sec_o[p]  = ~buf_en_i[p] & edge_match(edge_sel_i[SI], rise_i[SI], fall_i[SI]);
      end
    end
  endgenerate

endmodule

// File: rtl/icap_pair.sv
module icap_pair #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_i,
  input  logic          cap_prim_i,
  input  logic          cap_sec_i,
  input  logic          hist_i,
  input  logic          clr_prim_i,
  input  logic          clr_sec_i,
  output logic [CW-1:0] reg_prim_o,
  output logic [CW-1:0] reg_sec_o,
  output logic          flag_prim_o,
  output logic          flag_sec_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_prim_o <= '0;
      reg_sec_o  <= '0;
    end else begin
      if (cap_prim_i) begin
        reg_prim_o <= count_i;
        if (hist_i) reg_sec_o <= reg_prim_o;
      end
      if (cap_sec_i) reg_sec_o <= count_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_prim_o <= 1'b0;
      flag_sec_o  <= 1'b0;
    end else begin
      flag_prim_o <= cap_prim_i | (flag_prim_o & ~clr_prim_i);
      flag_sec_o  <= cap_sec_i  | (flag_sec_o  & ~clr_sec_i);
    end
  end

endmodule

// File: rtl/input_capture_bank.sv
module input_capture_bank #(
  parameter int CW        = 16,
  parameter int NUM_PAIRS = 2,
  parameter int SYNC_LEN  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CW-1:0]             count_i,
  input  logic [2*NUM_PAIRS-1:0]    cap_pin_i,
  input  logic [2*NUM_PAIRS-1:0]    edge_sel_i,
  input  logic [NUM_PAIRS-1:0]      buf_en_i,
  input  logic [2*NUM_PAIRS-1:0]    flag_clr_i,
  output logic [2*NUM_PAIRS*CW-1:0] cap_data_o,
  output logic [2*NUM_PAIRS-1:0]    flag_o
);

  localparam int NCH = 2 * NUM_PAIRS;

  logic [NCH-1:0]       rise, fall;
  logic [NUM_PAIRS-1:0] cap_prim, cap_sec;

  icap_sync #(.WIDTH(NCH), .STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (cap_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  icap_trigger #(.NUM_PAIRS(NUM_PAIRS)) u_trig (
    .rise_i     (rise),
    .fall_i     (fall),
    .edge_sel_i (edge_sel_i),
    .buf_en_i   (buf_en_i),
    .cap_prim_o (cap_prim),
    .cap_sec_o  (cap_sec)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
      localparam int SI = p + NUM_PAIRS;
      icap_pair #(.CW(CW)) u_pair (
        .clk         (clk),
        .rst         (rst),
        .count_i     (count_i),
        .cap_prim_i  (cap_prim[p]),
        .cap_sec_i   (cap_sec[p]),
        .hist_i      (buf_en_i[p]),
        .clr_prim_i  (flag_clr_i[p]),
        .clr_sec_i   (flag_clr_i[SI]),
        .reg_prim_o  (cap_data_o[p*CW +: CW]),
        .reg_sec_o   (cap_data_o[SI*CW +: CW]),
        .flag_prim_o (flag_o[p]),
        .flag_sec_o  (flag_o[SI])
      );
    end
  endgenerate

endmodule

// File: rtl/icap_checker.sv
module icap_checker #(
  parameter int CW        = 16,
  parameter int NUM_PAIRS = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [CW-1:0]             count_i,
  input logic [NUM_PAIRS-1:0]      buf_en_i,
  input logic [2*NUM_PAIRS-1:0]    flag_clr_i,
  input logic [2*NUM_PAIRS*CW-1:0] cap_data_o,
  input logic [2*NUM_PAIRS-1:0]    flag_o
);

  localparam int NCH = 2 * NUM_PAIRS;

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cap_data_o == '0) && (flag_o == '0)); // R1

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      AST_FLAG_STAMP: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o[i]) |-> cap_data_o[i*CW +: CW] == $past(count_i)); // R3

      AST_FLAG_FALL_CLR: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_o[i]) |-> $past(flag_clr_i[i])); // R6
    end

    for (i = 0; i < NUM_PAIRS; i++) begin : g_pr
      localparam int SI = i + NUM_PAIRS;

      AST_PRIM_CHANGE_FLAG: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_data_o[i*CW +: CW]) |-> flag_o[i]); // R2

      AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        ($past(buf_en_i[i]) && !$stable(cap_data_o[i*CW +: CW]))
        |-> cap_data_o[SI*CW +: CW] == $past(cap_data_o[i*CW +: CW])); // R7

      AST_HIST_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        $past(buf_en_i[i]) |-> !$rose(flag_o[SI])); // R9

      AST_SEC_CHANGE_SRC: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_data_o[SI*CW +: CW]) |-> ($past(buf_en_i[i]) || flag_o[SI])); // R10
    end
  endgenerate

endmodule

bind input_capture_bank icap_checker #(.CW(CW), .NUM_PAIRS(NUM_PAIRS)) u_icap_chk (
  .clk        (clk),
  .rst        (rst),
  .count_i    (count_i),
  .buf_en_i   (buf_en_i),
  .flag_clr_i (flag_clr_i),
  .cap_data_o (cap_data_o),
  .flag_o     (flag_o)
);

// File: tb/input_capture_bank_bench.sv
module input_capture_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] count = '0;
  logic [3:0]  pins = '0, esel = '0, clr = '0;
  logic [1:0]  ben = '0;
  logic [63:0] data;
  logic [3:0]  flags;

  int total = 0, fails = 0;
  logic [15:0] exp_reg [4];
  logic        exp_flag [4];
  bit          done = 0;

  always #5 clk = ~clk;

  input_capture_bank u_input_capture_bank (
    .clk(clk), .rst(rst), .count_i(count), .cap_pin_i(pins), .edge_sel_i(esel),
    .buf_en_i(ben), .flag_clr_i(clr), .cap_data_o(data), .flag_o(flags)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 4; i++) begin
      chk(req, $sformatf("reg%0d", i), {16'h0, data[i*16 +: 16]}, {16'h0, exp_reg[i]});
      chk(req, $sformatf("flag%0d", i), {31'h0, flags[i]}, {31'h0, exp_flag[i]});
    end
  endtask

  function automatic logic sel_hit(input logic sel, input logic r, input logic f);
    return sel ? r : f;
  endfunction

  // Expected effect of moving pins to newp, with count held steady.
  task automatic apply_pins(input logic [3:0] newp, input string req);
    for (int p = 0; p < 2; p++) begin
      logic ra, fa, rs, fs, ca, cs;
      ra = !pins[p] && newp[p];     fa = pins[p] && !newp[p];
      rs = !pins[p+2] && newp[p+2]; fs = pins[p+2] && !newp[p+2];
      if (ben[p] && (esel[p] != esel[p+2])) ca = ra | fa;
      else ca = sel_hit(esel[p], ra, fa);
      cs = !ben[p] && sel_hit(esel[p+2], rs, fs);
      if (ca) begin
        if (ben[p]) exp_reg[p+2] = exp_reg[p];
        exp_reg[p] = count;
        exp_flag[p] = 1'b1;
      end
      if (cs) begin
        exp_reg[p+2] = count;
        exp_flag[p+2] = 1'b1;
      end
    end
    pins = newp;
    step(4);
    check_all(req);
  endtask

  task automatic clear_flags(input logic [3:0] m, input string req);
    clr = m;
    step(1);
    clr = '0;
    for (int i = 0; i < 4; i++) if (m[i]) exp_flag[i] = 1'b0;
    step(1);
    check_all(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin exp_reg[i] = '0; exp_flag[i] = 1'b0; end
    step(3);
    check_all("R1");
    rst = 1'b0;
    step(1);
    check_all("R1");

    // R5 latency with a counter that moves every cycle; channel 0 rising
    esel = 4'b1111;
    step(4);
    count = 16'd100; pins[0] = 1'b1;
    step(1); chk("R5", "flag0 early", {31'h0, flags[0]}, 32'h0); count = 16'd101;
    step(1); chk("R5", "flag0 early", {31'h0, flags[0]}, 32'h0); count = 16'd102;
    step(1);
    exp_reg[0] = 16'd102; exp_flag[0] = 1'b1;
    check_all("R5");
    step(3);
    check_all("R5");

    // R2 falling select on channel 1: a rise is ignored, the fall captures
    esel[1] = 1'b0; count = 16'd200; step(4);
    apply_pins(pins | 4'b0010, "R2");
    apply_pins(pins & 4'b1101, "R2");

    // R4 overwrite while flag0 is still set
    apply_pins(pins & 4'b1110, "R4");
    count = 16'd300;
    apply_pins(pins | 4'b0001, "R4");

    // R6 plain clear
    clear_flags(4'b0001, "R6");

    // R6 clear in the same cycle as a capture on channel 1 (flag already set)
    esel[1] = 1'b1; step(4);
    count = 16'd400; pins[1] = 1'b1;
    step(2); clr = 4'b0010;
    step(1); clr = '0;
    exp_reg[1] = 16'd400; exp_flag[1] = 1'b1;
    check_all("R6");

    // R10 channel 2 on its own pin
    count = 16'd500;
    apply_pins(pins | 4'b0100, "R10");
    clear_flags(4'b0100, "R10");

    // R7/R8 history on pair 0 with equal selects: rising only
    ben = 2'b01; esel[0] = 1'b1; esel[2] = 1'b1; step(4);
    count = 16'd550;
    apply_pins(pins & 4'b1110, "R8");
    count = 16'd600;
    apply_pins(pins | 4'b0001, "R7");

    // R8 unequal selects: the falling edge captures too
    esel[2] = 1'b0; step(4);
    count = 16'd700;
    apply_pins(pins & 4'b1110, "R8");

    // R9 pin 2 ignored in history mode
    count = 16'd800;
    apply_pins(pins ^ 4'b0100, "R9");
    apply_pins(pins ^ 4'b0100, "R9");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom % 8;
      if (op == 0) begin
        esel = 4'($urandom); ben = 2'($urandom); step(4);
      end else if (op == 1) begin
        clear_flags(4'($urandom), "R6");
      end else begin
        logic [3:0] t;
        t = 4'($urandom);
        if (t == '0) t = 4'b0001;
        count = 16'($urandom);
        apply_pins(pins ^ t, "R8");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule